// File: doc/BRIEF.md
# Slotted Multi-Writer Transmit Queue

This block is the transmit queue of one output port of a packet switch. Its byte storage is cut into equal slots, and each slot holds exactly one packet. All packets in the network share one size class, which is chosen at configuration time. Up to NUM_HEADS source ports feed the queue through their own write heads. Each head offers one byte at a time with valid/ready. A round-robin arbiter accepts at most one byte per fabric clock. The fabric clock runs faster than the source ports, so several heads can hold partly written packets at once, each in its own slot.

A head claims the lowest free slot when its first byte is accepted. After one slot's worth of bytes the head hands the slot index to a completion FIFO. The read side takes indices out of that FIFO in the order the packets finished and streams each slot byte by byte, with a last-byte marker, towards the serializer. A slot becomes free again only once its final byte has been taken on the read port. A packet that starts while every slot is in use is still accepted byte by byte, but it is thrown away and flagged. There is no back-pressure towards the sources.

Top module: `tq_slot_queue`

## Requirements
- R1: During and right after reset, rd_valid and full are 0, every slot is free, and the size class is taken from cfg_size.
- R2: At most one wr_ready bit is high in any cycle. A head that holds wr_valid is accepted within NUM_HEADS cycles (round robin).
- R3: A packet is exactly 16 << cls bytes long, where cls is the active size class (cfg_size 0 means 16 bytes, 1 means 32, 2 means 64, 3 means 128).
- R4: Packets leave on the read port whole and in the order their last bytes were accepted, with their bytes in arrival order.
- R5: If the first byte of a packet is accepted while no slot is free, wr_drop of that head is high in that same cycle. All bytes of that packet are still accepted, and none of them ever appear on the read port. wr_drop is 0 at all other times.
- R6: full is high exactly when every slot of the active size class is in use.
- R7: A slot stays in use until the read-port handshake of its last byte, and it is free again from the next cycle on.
- R8: cfg_size is copied into the active size class only in a cycle in which every slot is free, no head is inside a packet and no wr_valid is high. At all other times cfg_size has no effect.
- R9: When the read side is idle, the first byte of a packet is valid on the read port after the second clock edge that follows the edge accepting its last write byte.
- R10: rd_last is high only on the final byte of a packet. While rd_valid is high and rd_ready is low, rd_data and rd_last hold their values.
- R11: The number of slots is QUEUE_BYTES divided by the packet size. With the default 2048 bytes this is 128, 64, 32 or 16 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 2 | Requested size class (0: 16 B, 1: 32 B, 2: 64 B, 3: 128 B) |
| wr_valid | input | NUM_HEADS | Per-head byte offered |
| wr_data | input | 8*NUM_HEADS | Per-head byte; head h uses bits 8h+7..8h |
| wr_ready | output | NUM_HEADS | Per-head byte accepted this cycle |
| wr_drop | output | NUM_HEADS | Accepted first byte starts a dropped packet |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Read byte is the last of its packet |
| rd_ready | input | 1 | Serializer takes the read byte |
| full | output | 1 | No free slot in the active size class |

## Verification
wr_ready and wr_drop are combinational on the current wr_valid, so they are sampled just before the edge they belong to, and the bench updates its slot accounting from them. full and the size class change on the edge after a claim or release, so each cycle's full value is compared with the model's count from before that cycle's updates. The read port is registered, and its first byte must show up exactly three sample points after the sample of the last write byte (R9). The bench checks this whenever the model shows the read side empty at that moment. rd_data and rd_last are compared at every handshake against the byte pattern and position the model expects.

// File: rtl/tq_pkg.sv
package tq_pkg;
    localparam int BYTE_W       = 8;
    localparam int CLS_W        = 2;
    localparam int MIN_SLOT_LOG = 4;
    localparam int NUM_CLS      = 4;
    localparam int MAX_SLOT_LOG = MIN_SLOT_LOG + NUM_CLS - 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_16  = 2'd0,
        CLS_32  = 2'd1,
        CLS_64  = 2'd2,
        CLS_128 = 2'd3
    } size_cls_e;

    // log2 of the packet length for a size class
    function automatic int unsigned cls_log(input size_cls_e c);
        return MIN_SLOT_LOG + int'(c);
    endfunction
endpackage

// File: rtl/tq_rr_arb.sv
module tq_rr_arb #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] ptr;

    always_comb begin
        int  j;
        logic found;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found    = 1'b1;
                gnt[j]   = 1'b1;
                gnt_idx  = IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (|req) begin
            ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end
endmodule

// File: rtl/tq_slot_alloc.sv
module tq_slot_alloc #(
    parameter int MAX_SLOTS = 128,
    parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W:0]   nslots,
    input  logic              claim,
    input  logic              release_en,
    input  logic [SLOT_W-1:0] release_idx,
    output logic [SLOT_W-1:0] pick_idx,
    output logic              any_free,
    output logic              all_free
);
    logic [MAX_SLOTS-1:0] free_q;

    // lowest free slot inside the active range
    always_comb begin
        pick_idx = '0;
        any_free = 1'b0;
        for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
            if (free_q[i] && ((SLOT_W+1)'(i) < nslots)) begin
                pick_idx = SLOT_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign all_free = &free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '1;
        end else begin
            if (claim)      free_q[pick_idx]    <= 1'b0;
            if (release_en) free_q[release_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/tq_index_fifo.sv
module tq_index_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 7,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         nonempty
);
    logic [W-1:0] store [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW:0]   count;

    assign pop_data = store[rptr];
    assign nonempty = (count != '0);

    always_ff @(posedge clk) begin
        if (push) store[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tq_head.sv
module tq_head #(
    parameter int SLOT_W = 7,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    input  logic              any_free,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic [CNT_W-1:0]  size_m1,
    output logic              busy,
    output logic              claim,
    output logic              drop_now,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [CNT_W-1:0]  wr_off,
    output logic              complete
);
    typedef struct packed {
        logic              busy;
        logic              dropping;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
    } head_t;

    head_t st;
    logic  first, at_end;

    always_comb begin
        first    = grant && !st.busy;
        at_end   = (st.cnt == size_m1);
        claim    = first && any_free;
        drop_now = first && !any_free;
        wr_en    = claim || (grant && st.busy && !st.dropping);
        wr_slot  = claim ? alloc_slot : st.slot;
        wr_off   = st.busy ? st.cnt : '0;
        complete = grant && st.busy && !st.dropping && at_end;
        busy     = st.busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (first) begin
            st.busy     <= 1'b1;
            st.dropping <= !any_free;
            st.slot     <= alloc_slot;
            st.cnt      <= CNT_W'(1);
        end else if (grant && st.busy) begin
            if (at_end) begin
                st.busy <= 1'b0;
                st.cnt  <= '0;
            end else begin
                st.cnt  <= st.cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tq_slot_queue.sv
module tq_slot_queue
    import tq_pkg::*;
#(
    parameter int NUM_HEADS   = 4,
    parameter int QUEUE_BYTES = 2048
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CLS_W-1:0]            cfg_size,
    input  logic [NUM_HEADS-1:0]        wr_valid,
    input  logic [NUM_HEADS*BYTE_W-1:0] wr_data,
    output logic [NUM_HEADS-1:0]        wr_ready,
    output logic [NUM_HEADS-1:0]        wr_drop,
    output logic                        rd_valid,
    output logic [BYTE_W-1:0]           rd_data,
    output logic                        rd_last,
    input  logic                        rd_ready,
    output logic                        full
);
    localparam int ADDR_W    = $clog2(QUEUE_BYTES);
    localparam int MAX_SLOTS = QUEUE_BYTES >> MIN_SLOT_LOG;
    localparam int SLOT_W    = $clog2(MAX_SLOTS);
    localparam int CNT_W     = MAX_SLOT_LOG;
    localparam int HEAD_W    = (NUM_HEADS > 1) ? $clog2(NUM_HEADS) : 1;

    // active size class and derived geometry
    size_cls_e         cls_q;
    int unsigned       shift;
    logic [CNT_W-1:0]  size_m1;
    logic [SLOT_W:0]   nslots;

    always_comb begin
        shift   = cls_log(cls_q);
        size_m1 = CNT_W'((32'd1 << shift) - 32'd1);
        nslots  = (SLOT_W+1)'(QUEUE_BYTES >> shift);
    end

    // arbitration
    logic [NUM_HEADS-1:0] gnt;
    logic [HEAD_W-1:0]    gnt_idx;

    tq_rr_arb #(.N(NUM_HEADS), .IDX_W(HEAD_W)) u_arb (
        .clk(clk), .rst(rst), .req(wr_valid), .gnt(gnt), .gnt_idx(gnt_idx)
    );
    assign wr_ready = gnt;

    // slot allocation
    logic [SLOT_W-1:0] pick_idx;
    logic              any_free, all_free;
    logic              do_claim, do_release;
    logic [SLOT_W-1:0] release_idx;

    tq_slot_alloc #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_alloc (
        .clk(clk), .rst(rst), .nslots(nslots),
        .claim(do_claim), .release_en(do_release), .release_idx(release_idx),
        .pick_idx(pick_idx), .any_free(any_free), .all_free(all_free)
    );
    assign full = !any_free;

    // write heads
    logic [NUM_HEADS-1:0] h_busy, h_claim, h_drop, h_wr_en, h_complete;
    logic [SLOT_W-1:0]    h_wr_slot [NUM_HEADS];
    logic [CNT_W-1:0]     h_wr_off  [NUM_HEADS];

    for (genvar h = 0; h < NUM_HEADS; h++) begin : g_head
        tq_head #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_head (
            .clk(clk), .rst(rst), .grant(gnt[h]), .any_free(any_free),
            .alloc_slot(pick_idx), .size_m1(size_m1),
            .busy(h_busy[h]), .claim(h_claim[h]), .drop_now(h_drop[h]),
            .wr_en(h_wr_en[h]), .wr_slot(h_wr_slot[h]), .wr_off(h_wr_off[h]),
            .complete(h_complete[h])
        );
    end

    assign wr_drop  = h_drop;
    assign do_claim = |h_claim;

    logic              mem_we, push;
    logic [ADDR_W-1:0] waddr;
    byte_t             wbyte;
    logic [SLOT_W-1:0] push_slot;

    always_comb begin
        mem_we    = |h_wr_en;
        push      = |h_complete;
        push_slot = h_wr_slot[gnt_idx];
        waddr     = ADDR_W'((int'(h_wr_slot[gnt_idx]) << shift) | int'(h_wr_off[gnt_idx]));
        wbyte     = wr_data[gnt_idx*BYTE_W +: BYTE_W];
    end

    // completion order
    logic              pop, fifo_ne;
    logic [SLOT_W-1:0] fifo_head;

    tq_index_fifo #(.DEPTH(MAX_SLOTS), .W(SLOT_W)) u_done (
        .clk(clk), .rst(rst), .push(push), .push_data(push_slot),
        .pop(pop), .pop_data(fifo_head), .nonempty(fifo_ne)
    );

    // read side
    logic              rd_active, load;
    logic [SLOT_W-1:0] rd_slot, out_slot;
    logic [CNT_W-1:0]  rd_cnt;
    logic [ADDR_W-1:0] raddr;
    byte_t             mem [QUEUE_BYTES];

    always_comb begin
        pop         = !rd_active && fifo_ne;
        load        = rd_active && (!rd_valid || rd_ready);
        raddr       = ADDR_W'((int'(rd_slot) << shift) | int'(rd_cnt));
        do_release  = rd_valid && rd_ready && rd_last;
        release_idx = out_slot;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[waddr] <= wbyte;
        if (load)   rd_data    <= mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_active <= 1'b0;
            rd_slot   <= '0;
            rd_cnt    <= '0;
            rd_valid  <= 1'b0;
            rd_last   <= 1'b0;
            out_slot  <= '0;
        end else begin
            if (pop) begin
                rd_active <= 1'b1;
                rd_slot   <= fifo_head;
                rd_cnt    <= '0;
            end else if (load) begin
                rd_cnt <= rd_cnt + 1'b1;
                if (rd_cnt == size_m1) rd_active <= 1'b0;
            end
            if (load) begin
                rd_valid <= 1'b1;
                rd_last  <= (rd_cnt == size_m1);
                out_slot <= rd_slot;
            end else if (rd_valid && rd_ready) begin
                rd_valid <= 1'b0;
                rd_last  <= 1'b0;
            end
        end
    end

    // size class: taken over only while the queue is empty and quiet
    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= size_cls_e'(cfg_size);
        end else if (all_free && !(|h_busy) && !(|wr_valid)) begin
            cls_q <= size_cls_e'(cfg_size);
        end
    end
endmodule

// File: rtl/tq_slot_queue_chk.sv
module tq_slot_queue_chk #(
    parameter int NUM_HEADS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_HEADS-1:0] wr_valid,
    input logic [NUM_HEADS-1:0] wr_ready,
    input logic [NUM_HEADS-1:0] wr_drop,
    input logic                 rd_valid,
    input logic                 rd_ready,
    input logic [7:0]           rd_data,
    input logic                 rd_last,
    input logic                 full,
    input logic [1:0]           cls_q
);
    localparam int WC_W = $clog2(NUM_HEADS + 1) + 1;

    p_reset_r1: assert property (@(posedge clk) rst |=> (!rd_valid && !full));

    p_one_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_ready));

    for (genvar h = 0; h < NUM_HEADS; h++) begin : g_wait
        logic [WC_W-1:0] wait_cnt;
        always_ff @(posedge clk) begin
            if (rst || !wr_valid[h] || wr_ready[h]) wait_cnt <= '0;
            else if (wait_cnt != '1)                wait_cnt <= wait_cnt + 1'b1;
        end
        p_fair_wait_r2: assert property (@(posedge clk) disable iff (rst)
            int'(wait_cnt) < NUM_HEADS);
    end

    p_drop_accepted_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_drop & ~wr_ready) == '0);

    p_drop_when_full_r5: assert property (@(posedge clk) disable iff (rst)
        (|wr_drop) |-> full);

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(cls_q));

    p_hold_out_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));
endmodule

bind tq_slot_queue tq_slot_queue_chk #(.NUM_HEADS(NUM_HEADS)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_drop(wr_drop), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .full(full), .cls_q(cls_q)
);

// File: tb/sim_tq_slot_queue.sv
`timescale 1ns/1ps
module sim_tq_slot_queue;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 4;
    localparam int QB = 2048;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        cfg_size;
    logic [NH-1:0]     wr_valid;
    logic [NH*8-1:0]   wr_data;
    logic [NH-1:0]     wr_ready, wr_drop;
    logic              rd_valid, rd_last, rd_ready, full;
    logic [7:0]        rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tq_slot_queue #(.NUM_HEADS(NH), .QUEUE_BYTES(QB)) u0 (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .wr_drop(wr_drop),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_ready(rd_ready), .full(full)
    );

    int errors = 0, checks = 0, cyc = 0;
    int in_use = 0, cls_m = 0, next_id = 1, rcnt = 0, drops_seen = 0;
    int budget = 0, start_prob = 0, vprob = 100, rprob = 100, cfg_next = 0;
    bit auto_start = 0, lat_armed = 0;
    int lat_start = 0;
    bit pend[NH], offer[NH], hdrop[NH];
    int hid[NH], hcnt[NH];
    int exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] pat(input int id, input int i);
        return 8'((id * 37 + i * 11 + 5) & 255);
    endfunction
    function automatic int nslots_of(input int c); return QB >> (4 + c); endfunction
    function automatic int size_of(input int c);   return 16 << c;       endfunction

    function automatic bit heads_idle();
        for (int h = 0; h < NH; h++) if (pend[h] || hcnt[h] != 0) return 0;
        return 1;
    endfunction

    task automatic step();
        int  in_pre;
        bit  idle_pre, accepted, ed, last_exp;
        @(negedge clk);
        cyc++;
        cfg_size = 2'(cfg_next);
        for (int h = 0; h < NH; h++) begin
            if (!pend[h] && hcnt[h] == 0 && auto_start && budget > 0 &&
                int'($urandom % 100) < start_prob) begin
                pend[h] = 1; hid[h] = next_id++; budget--;
            end
            if (!offer[h] && (pend[h] || hcnt[h] > 0) && int'($urandom % 100) < vprob)
                offer[h] = 1;
            wr_valid[h] = offer[h];
            wr_data[h*8 +: 8] = pat(hid[h], hcnt[h]);
        end
        rd_ready = int'($urandom % 100) < rprob;
        #4;
        in_pre   = in_use;
        idle_pre = (in_use == 0) && (wr_valid == '0);
        for (int h = 0; h < NH; h++) if (hcnt[h] != 0) idle_pre = 0;
        // R6 R7 R11: full tracks slots in use against the active slot count
        chk(full == (in_use == nslots_of(cls_m)), "R6 R7 R11", "full", int'(full),
            int'(in_use == nslots_of(cls_m)));
        chk($countones(wr_ready) <= 1, "R2", "grants per cycle", $countones(wr_ready), 1);
        // read port
        if (rd_valid && lat_armed) begin
            chk(cyc - lat_start == 3, "R9", "first byte delay", cyc - lat_start, 3);
            lat_armed = 0;
        end
        if (rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4", "unexpected read byte", int'(rd_data), -1);
            end else begin
                last_exp = (rcnt == size_of(cls_m) - 1);
                chk(rd_data == pat(exp_q[0], rcnt), "R4", "read byte",
                    int'(rd_data), int'(pat(exp_q[0], rcnt)));
                chk(rd_last == last_exp, "R3 R10", "rd_last", int'(rd_last), int'(last_exp));
                if (last_exp) begin
                    void'(exp_q.pop_front());
                    rcnt = 0;
                    in_use--;
                end else begin
                    rcnt++;
                end
            end
        end
        // write heads
        for (int h = 0; h < NH; h++) begin
            accepted = offer[h] && wr_ready[h];
            if (accepted && hcnt[h] == 0) begin
                ed = (in_pre == nslots_of(cls_m));
                chk(wr_drop[h] == ed, "R5", "drop on first byte", int'(wr_drop[h]), int'(ed));
                hdrop[h] = ed;
                if (ed) drops_seen++; else in_use++;
                pend[h] = 0;
            end else begin
                chk(wr_drop[h] == 0, "R5", "stray drop", int'(wr_drop[h]), 0);
            end
            if (accepted) begin
                offer[h] = 0;
                hcnt[h]++;
                if (hcnt[h] == size_of(cls_m)) begin
                    hcnt[h] = 0;
                    if (!hdrop[h]) begin
                        if (exp_q.size() == 0) begin lat_armed = 1; lat_start = cyc; end
                        exp_q.push_back(hid[h]);
                    end
                end
            end
        end
        if (idle_pre) cls_m = cfg_next;
    endtask

    task automatic drain();
        auto_start = 0; vprob = 100; rprob = 100;
        for (int n = 0; n < 20000; n++) begin
            if (heads_idle() && exp_q.size() == 0 && in_use == 0) break;
            step();
        end
        step();
        chk(exp_q.size() == 0, "R4", "packets left after drain", exp_q.size(), 0);
        chk(rd_valid == 0, "R4", "rd_valid after drain", int'(rd_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        rst = 1; cfg_size = 2'd0; wr_valid = '0; wr_data = '0; rd_ready = 0;
        for (int h = 0; h < NH; h++) begin pend[h] = 0; offer[h] = 0; hdrop[h] = 0; hid[h] = 0; hcnt[h] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(rd_valid == 0, "R1", "rd_valid in reset", int'(rd_valid), 0);
        chk(full == 0, "R1", "full in reset", int'(full), 0);
        chk(wr_ready == '0, "R1", "wr_ready idle", int'(wr_ready), 0);
        rst = 0;

        // R9 R3: one packet, 16 bytes, idle read side
        auto_start = 1; budget = 1; start_prob = 100; vprob = 100; rprob = 100;
        repeat (40) step();
        drain();

        // R2 R4: all heads at once, full rate
        auto_start = 1; budget = 12; start_prob = 100; vprob = 100; rprob = 100;
        repeat (300) step();
        drain();

        // R5 R6 R7 R8 R11: 128-byte class, 16 slots, read port stalled
        cfg_next = 3; repeat (3) step();
        chk(cls_m == 3, "R8", "class taken while idle", cls_m, 3);
        drops_seen = 0;
        auto_start = 1; budget = 18; start_prob = 100; vprob = 100; rprob = 0;
        for (int n = 0; n < 4000; n++) begin
            if (budget == 0 && heads_idle()) break;
            step();
        end
        chk(drops_seen == 2, "R5", "dropped packets", drops_seen, 2);
        chk(exp_q.size() == 16, "R5", "stored packets", exp_q.size(), 16);
        chk(full == 1, "R11", "full at 16 slots", int'(full), 1);
        cfg_next = 0;          // R8: must be ignored while slots are in use
        repeat (5) step();
        chk(full == 1, "R7", "still full without reads", int'(full), 1);
        drain();               // lengths stay at 128 bytes
        auto_start = 1; budget = 2; start_prob = 100; rprob = 100;
        repeat (100) step();
        drain();               // now 16 bytes each

        // random mix with class changes
        for (int round = 0; round < 4; round++) begin
            cfg_next = int'($urandom % 4);
            auto_start = 1; budget = 100000; start_prob = 25; vprob = 70; rprob = 35;
            repeat (4000) step();
            drain();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule